// File: doc/BRIEF.md
# Modem Line Status Register with Sticky Change Flags

This block watches four modem handshake lines (clear-to-send, data-set-ready, ring indicator and carrier detect) and presents them to a processor as one 8-bit status byte. The upper nibble shows the present level of each line. The lower nibble holds sticky change flags. A flag sets when its line changes, and all flags clear when the processor completes a read. The lines arrive here already synchronized to `clk`.

A loopback switch from a control register makes the status nibble follow four internal modem-control outputs in place of the pins, so software can exercise the path without external wiring. The read port is a level strobe that may stay high for any number of cycles. The byte on `rd_data_o` is valid for as long as the strobe is high. The processor owns the strobe, so the port has no back-pressure and no handshake. Flags are frozen while the strobe is high. Any change that arrives during the read is settled on the cycle after the strobe falls. It sets a flag that was clear when the read began and cancels a flag that was already set.

Top module: `modem_status_reg`

## Requirements
- R1: With loopback off, `rd_data_o[4]` is clear-to-send, `[5]` is data-set-ready, `[6]` is ring indicator and `[7]` is carrier detect. These follow the pins combinationally, with no mask or other setting in the way.
- R2: With loopback on, bits `[4]`..`[7]` follow `loop_rts_i`, `loop_dtr_i`, `loop_out1_i` and `loop_out2_i` respectively. The four pins then have no effect on any output bit.
- R3: Outside a read, any change of clear-to-send, data-set-ready or carrier detect sets flag bit 0, 1 or 3 respectively on the next rising clock edge.
- R4: Flag bit 2 sets only when the ring-indicator level falls from 1 to 0. A rise leaves the flag unchanged.
- R5: Outside a read, a set flag stays set for any number of cycles.
- R6: A read is the strobe held high for one or more cycles and then dropped. On the edge after the strobe falls, every flag with no change during the read clears. Bits `[7:4]` are not affected by the read.
- R7: No flag changes on any clock edge at which the strobe is sampled high.
- R8: If a flag was clear when a read began and its line changed during the read, the flag is set on the edge after the strobe falls.
- R9: If a flag was set when a read began, it is clear after the strobe falls, even if its line changed again during the read.
- R10: While reset is asserted all flags read 0. The line levels present at reset are taken as the baseline, so lines that do not change never raise a flag after reset.
- R11: Switching loopback on or off counts as a change for every line whose selected level differs between the two sources. The R3/R4 rules apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cts_i | input | 1 | Clear-to-send pin, synchronized |
| dsr_i | input | 1 | Data-set-ready pin, synchronized |
| ri_i | input | 1 | Ring-indicator pin, synchronized |
| dcd_i | input | 1 | Carrier-detect pin, synchronized |
| loop_en_i | input | 1 | Loopback select from control register |
| loop_rts_i | input | 1 | Internal RTS output, loop source for bit 4 |
| loop_dtr_i | input | 1 | Internal DTR output, loop source for bit 5 |
| loop_out1_i | input | 1 | Internal OUT1 output, loop source for bit 6 |
| loop_out2_i | input | 1 | Internal OUT2 output, loop source for bit 7 |
| rd_strobe_i | input | 1 | Read strobe, level, any length |
| rd_data_o | output | 8 | Status byte: levels in [7:4], change flags in [3:0] |

## Verification
The bench targets line changes that land inside a read window. If the freeze were missing, a flag would pop up mid-read and then be lost when the read clears it. If the race resolution were wrong, a set flag would survive a second change, or a fresh change would be lost at the falling edge of the strobe. Ring-indicator rises are checked for a spurious flag. Loopback is checked with pin activity that must not leak through, and with mode switches that must raise exactly the flags of lines whose level differs. Reset is released with nonzero line levels to catch a design that compares against zero rather than the captured baseline.

// File: rtl/msr_pkg.sv
package msr_pkg;
  localparam int unsigned LINES = 4;
  localparam int unsigned BYTE_W = 2 * LINES;

  // line order inside every vector; bit position of the status byte depends on it
  localparam int unsigned L_CTS = 0;
  localparam int unsigned L_DSR = 1;
  localparam int unsigned L_RI  = 2;
  localparam int unsigned L_DCD = 3;

  // lines whose flag reacts only to a 1->0 transition
  localparam logic [LINES-1:0] FALL_ONLY_MASK = LINES'(1) << L_RI;

  typedef logic [LINES-1:0] line_vec_t;
endpackage

// File: rtl/msr_src_sel.sv
module msr_src_sel #(
  parameter int unsigned W = 4
) (
  input  logic         loop_en,
  input  logic [W-1:0] pin_vec,
  input  logic [W-1:0] loop_vec,
  output logic [W-1:0] sel_vec
);
  always_comb begin
    sel_vec = loop_en ? loop_vec : pin_vec;
  end
endmodule

// File: rtl/msr_change_det.sv
module msr_change_det #(
  parameter int unsigned W = 4,
  parameter logic [W-1:0] FALL_ONLY = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur,
  output logic [W-1:0] evt
);
  logic [W-1:0] prev_q;

  // reset captures the present levels as the baseline
  always_ff @(posedge clk) begin
    prev_q <= cur;
  end

  for (genvar i = 0; i < W; i++) begin : g_line
    if (FALL_ONLY[i]) begin : g_fall
      assign evt[i] = rst_n & prev_q[i] & ~cur[i];
    end else begin : g_any
      assign evt[i] = rst_n & (prev_q[i] ^ cur[i]);
    end
  end
endmodule

// File: rtl/msr_delta_ctl.sv
module msr_delta_ctl #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd,
  input  logic [W-1:0] evt,
  output logic [W-1:0] flags
);
  logic         rd_q;
  logic [W-1:0] pend_q;
  logic         trail;

  assign trail = rd_q & ~rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      pend_q <= '0;
      flags  <= '0;
    end else begin
      rd_q <= rd;
      if (trail) begin
        // a change seen during the read sets a clear flag, cancels a set one
        flags  <= (pend_q | evt) & ~flags;
        pend_q <= '0;
      end else if (rd) begin
        pend_q <= pend_q | evt;
      end else begin
        flags <= flags | evt;
      end
    end
  end
endmodule

// File: rtl/modem_status_reg.sv
module modem_status_reg
  import msr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cts_i,
  input  logic       dsr_i,
  input  logic       ri_i,
  input  logic       dcd_i,
  input  logic       loop_en_i,
  input  logic       loop_rts_i,
  input  logic       loop_dtr_i,
  input  logic       loop_out1_i,
  input  logic       loop_out2_i,
  input  logic       rd_strobe_i,
  output logic [7:0] rd_data_o
);
  line_vec_t pins, loops, live, evt, flags;

  always_comb begin
    pins         = '0;
    pins[L_CTS]  = cts_i;
    pins[L_DSR]  = dsr_i;
    pins[L_RI]   = ri_i;
    pins[L_DCD]  = dcd_i;
    loops        = '0;
    loops[L_CTS] = loop_rts_i;
    loops[L_DSR] = loop_dtr_i;
    loops[L_RI]  = loop_out1_i;
    loops[L_DCD] = loop_out2_i;
  end

  msr_src_sel #(.W(LINES)) u_sel (
    .loop_en  (loop_en_i),
    .pin_vec  (pins),
    .loop_vec (loops),
    .sel_vec  (live)
  );

  msr_change_det #(.W(LINES), .FALL_ONLY(FALL_ONLY_MASK)) u_det (
    .clk   (clk),
    .rst_n (rst_n),
    .cur   (live),
    .evt   (evt)
  );

  msr_delta_ctl #(.W(LINES)) u_dlt (
    .clk   (clk),
    .rst_n (rst_n),
    .rd    (rd_strobe_i),
    .evt   (evt),
    .flags (flags)
  );

  assign rd_data_o = {live, flags};
endmodule

// File: rtl/msr_checker.sv
module msr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cts_i,
  input logic       dsr_i,
  input logic       ri_i,
  input logic       dcd_i,
  input logic       loop_en_i,
  input logic       rd_strobe_i,
  input logic [7:0] rd_data_o
);
  logic       ok_q;
  logic       rd_q;
  logic [3:0] live_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ok_q <= 1'b0;
      rd_q <= 1'b0;
    end else begin
      ok_q <= 1'b1;
      rd_q <= rd_strobe_i;
    end
    live_q <= rd_data_o[7:4];
  end

  // R1
  a_r1_pin_levels: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_en_i |-> rd_data_o[7:4] == {dcd_i, ri_i, dsr_i, cts_i});

  // R7
  a_r7_frozen_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe_i |=> $stable(rd_data_o[3:0]));

  // R3
  a_r3_cts_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ok_q && !rd_strobe_i && !rd_q && (rd_data_o[4] != live_q[0]) |=> rd_data_o[0]);

  // R4
  a_r4_ri_rise_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ok_q && !rd_strobe_i && !rd_q && !rd_data_o[2] && !(live_q[2] && !rd_data_o[6])
    |=> !rd_data_o[2]);

  // R9
  a_r9_set_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    rd_q && !rd_strobe_i && rd_data_o[1] |=> !rd_data_o[1]);
endmodule

bind modem_status_reg msr_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cts_i       (cts_i),
  .dsr_i       (dsr_i),
  .ri_i        (ri_i),
  .dcd_i       (dcd_i),
  .loop_en_i   (loop_en_i),
  .rd_strobe_i (rd_strobe_i),
  .rd_data_o   (rd_data_o)
);

// File: tb/modem_status_reg_tb_top.sv
module modem_status_reg_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cts = 0, dsr = 0, ri = 0, dcd = 0;
  logic lp = 0, rts = 0, dtr = 0, o1 = 0, o2 = 0;
  logic rd = 0;
  logic [7:0] dout;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  modem_status_reg dut_i (
    .clk(clk), .rst_n(rst_n), .cts_i(cts), .dsr_i(dsr), .ri_i(ri), .dcd_i(dcd),
    .loop_en_i(lp), .loop_rts_i(rts), .loop_dtr_i(dtr), .loop_out1_i(o1),
    .loop_out2_i(o2), .rd_strobe_i(rd), .rd_data_o(dout)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read(input int len);
    rd = 1'b1;
    tick(len);
    rd = 1'b0;
    tick(1);
  endtask

  task automatic t_reset();
    cts = 1; ri = 1; dsr = 0; dcd = 0;
    tick(3);
    chk("R10 flags in reset", dout & 8'h0F, 8'h00);
    rst_n = 1'b1;
    tick(3);
    chk("R10 baseline after reset", dout, 8'h50);
  endtask

  task automatic t_live();
    cts = 0; dsr = 1; ri = 0; dcd = 1;
    #1 chk("R1 levels pattern A", dout & 8'hF0, 8'hA0);
    tick(1);
    cts = 1; dsr = 0; ri = 1; dcd = 0;
    #1 chk("R1 levels pattern B", dout & 8'hF0, 8'h50);
    tick(1);
    do_read(1);
    chk("R6 flags cleared, levels kept", dout, 8'h50);
  endtask

  task automatic t_delta();
    cts = 0; tick(1);
    chk("R3 cts change", dout, 8'h41);
    tick(4);
    chk("R5 flag sticky", dout, 8'h41);
    dsr = 1; dcd = 1; tick(1);
    chk("R3 dsr and dcd change", dout, 8'hEB);
    do_read(3);
    chk("R6 read clears flags", dout, 8'hE0);
  endtask

  task automatic t_ri();
    ri = 0; tick(1);
    chk("R4 ri fall sets", dout, 8'hA4);
    do_read(1);
    ri = 1; tick(2);
    chk("R4 ri rise ignored", dout, 8'hE0);
  endtask

  task automatic t_race_clear();
    rd = 1; tick(1);
    cts = 1; tick(1);
    chk("R7 no flag during read", dout, 8'hF0);
    tick(1);
    rd = 0; tick(1);
    chk("R8 change in read sets after", dout, 8'hF1);
  endtask

  task automatic t_race_set();
    dsr = 0; tick(1);
    chk("R3 dsr change", dout, 8'hD3);
    rd = 1; tick(1);
    cts = 0; dcd = 0; tick(1);
    chk("R7 frozen during read", dout, 8'h43);
    rd = 0; tick(1);
    chk("R9 set flag cancelled, R8 dcd set", dout, 8'h48);
    do_read(2);
    chk("R6 clear after race", dout, 8'h40);
  endtask

  task automatic t_loop();
    ri = 0; tick(1); do_read(1);
    cts = 0; dsr = 0; ri = 0; dcd = 0;
    rts = 1; dtr = 0; o1 = 0; o2 = 1;
    tick(1);
    chk("R2 sources idle when off", dout, 8'h00);
    lp = 1; tick(1);
    chk("R11 switch to loop", dout, 8'h99);
    cts = 1; dsr = 1; ri = 1; dcd = 1; tick(2);
    chk("R2 pins ignored in loop", dout, 8'h99);
    o1 = 1; tick(1); o1 = 0; tick(1);
    chk("R2 R4 loop out1 fall", dout, 8'h9D);
    do_read(1);
    chk("R6 clear in loop", dout, 8'h90);
    lp = 0; tick(1);
    chk("R11 switch back to pins", dout, 8'hF2);
  endtask

  initial begin
    tick(1);
    t_reset();
    t_live();
    t_delta();
    t_ri();
    t_race_clear();
    t_race_set();
    t_loop();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++; nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule